// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array

This block is a programmable logic array. It has N_IN live inputs, N_TERM product terms and N_OUT outputs. A personality is held in registers and has two planes. The AND plane holds one row per term and says, for each input, whether the term uses the true literal, the complement literal, or ignores the input. The OR plane holds one row per term and says which outputs that term feeds. A single term may feed several outputs, so a term that several outputs share is stored only once.

The personality is loaded one term at a time through a write port. Each write carries a term index, a 2*N_IN-bit AND row and an N_OUT-bit OR row. A synchronous clear returns every cell to one of two erased states. In the fused state every connection is present. In the blank state every connection is absent. A readback port returns the stored rows of any term. The outputs are a purely combinational function of the live inputs and the stored planes.

Top module: `pla_core`

## Requirements
- R1: While `rstN` is low, and after it is released, every AND cell reads back as 2'b11 and every OR bit as 1, until the first clear or write. In this state `outVec` is all zero for every input pattern.
- R2: When `wrEn` is high, `clrReq` is low and `wrTerm < N_TERM` at a rising edge, that term's AND and OR rows take the values of `wrAnd` and `wrOr`. From the next cycle, the readback port and `outVec` reflect the new rows.
- R3: Input i owns AND-row bits 2i and 2i+1. Bit 2i set means the term needs input i to be 1. Bit 2i+1 set means the term needs input i to be 0. The value 2'b00 makes the term ignore input i. The value 2'b11 forces the term to 0.
- R4: OR-row bit j connects a term to `outVec[j]`. Each output is the OR of the terms connected to it, and one term may drive several outputs.
- R5: A term whose AND cells are all 2'b00 evaluates to 1. An output with no connected term is 0.
- R6: When `clrReq` is high at a rising edge, every cell is rewritten. With `clrMode` = 1, every AND cell becomes 2'b11 and every OR bit becomes 1. With `clrMode` = 0, every AND cell becomes 2'b00 and every OR bit becomes 0.
- R7: A clear and a write in the same cycle resolve as the clear alone.
- R8: A write with `wrTerm >= N_TERM` changes no stored cell and no output.
- R9: `outVec` follows a change of `inVec` within the same cycle, with no clock edge.
- R10: For 3 inputs A=`inVec[0]`, B=`inVec[1]`, C=`inVec[2]`, the array is loaded with the terms AB, B'C, AC', B'C' and A. It must then give F0=B'C'+A, F1=AB+AC', F2=AB+B'C' and F3=B'C+A on `outVec[0..3]` for all 8 input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to the fused state |
| clrReq | input | 1 | Synchronous clear of the whole personality |
| clrMode | input | 1 | Clear target: 1 fused (all connected), 0 blank |
| wrEn | input | 1 | Row write enable |
| wrTerm | input | TERM_W | Term index of the write |
| wrAnd | input | 2*N_IN | AND row to store |
| wrOr | input | N_OUT | OR row to store |
| rdTerm | input | TERM_W | Term index for readback |
| rdAnd | output | 2*N_IN | Stored AND row of `rdTerm` (0 if out of range) |
| rdOr | output | N_OUT | Stored OR row of `rdTerm` (0 if out of range) |
| inVec | input | N_IN | Live inputs |
| outVec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench targets the places where the encoding is easy to get wrong. A design that swapped the two bits of a cell, or read 2'b11 as "ignore", would break the shared-term example and the forced-zero row. A design that reduced an all-ignore term to 0, or an unconnected output to 1, would show up in the blank-clear and single-term phases. A design that let a write win over a simultaneous clear, or that let an out-of-range index alias onto a real row, would fail the readback comparison made on every cycle. A registered output path would fail the mid-cycle input-change checks.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // strobes from control to the plane storage
  typedef struct packed {
    logic load;   // commit one row
    logic clear;  // rewrite the whole personality
    logic fill;   // clear value: 1 connected, 0 blank
  } pla_strb_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int N_TERM = 5,
  parameter int TERM_W = 3
) (
  input  logic              clrReq,
  input  logic              clrMode,
  input  logic              wrEn,
  input  logic [TERM_W-1:0] wrTerm,
  output pla_strb_t         strb
);
  logic inRange;

  assign inRange = 32'(wrTerm) < 32'(N_TERM);

  always_comb begin
    strb.clear = clrReq;
    strb.fill  = clrMode;
    strb.load  = wrEn && !clrReq && inRange;
  end
endmodule

// File: rtl/pla_store.sv
module pla_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int TERM_W = 3,
  localparam int ROW_W = 2 * N_IN
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pla_strb_t                         strb,
  input  logic [TERM_W-1:0]                 wrTerm,
  input  logic [ROW_W-1:0]                  wrAnd,
  input  logic [N_OUT-1:0]                  wrOr,
  input  logic [TERM_W-1:0]                 rdTerm,
  output logic [ROW_W-1:0]                  rdAnd,
  output logic [N_OUT-1:0]                  rdOr,
  output logic [N_TERM-1:0][ROW_W-1:0]      andPlane,
  output logic [N_TERM-1:0][N_OUT-1:0]      orPlane
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andPlane <= '1;
      orPlane  <= '1;
    end else if (strb.clear) begin
      andPlane <= strb.fill ? '1 : '0;
      orPlane  <= strb.fill ? '1 : '0;
    end else if (strb.load) begin
      for (int t = 0; t < N_TERM; t++) begin
        if (wrTerm == TERM_W'(t)) begin
          andPlane[t] <= wrAnd;
          orPlane[t]  <= wrOr;
        end
      end
    end
  end

  always_comb begin
    rdAnd = '0;
    rdOr  = '0;
    for (int t = 0; t < N_TERM; t++) begin
      if (rdTerm == TERM_W'(t)) begin
        rdAnd = andPlane[t];
        rdOr  = orPlane[t];
      end
    end
  end
endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  localparam int ROW_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]                   inVec,
  input  logic [N_TERM-1:0][ROW_W-1:0]      andPlane,
  input  logic [N_TERM-1:0][N_OUT-1:0]      orPlane,
  output logic [N_OUT-1:0]                  outVec
);
  logic [N_TERM-1:0] termHit;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_comb begin
      termHit[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (andPlane[t][2*i] && !inVec[i])  termHit[t] = 1'b0;
        if (andPlane[t][2*i+1] && inVec[i]) termHit[t] = 1'b0;
      end
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] colMask;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign colMask[t] = orPlane[t][j];
    end
    assign outVec[j] = |(termHit & colMask);
  end
endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  localparam int TERM_W = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int ROW_W  = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrReq,
  input  logic              clrMode,
  input  logic              wrEn,
  input  logic [TERM_W-1:0] wrTerm,
  input  logic [ROW_W-1:0]  wrAnd,
  input  logic [N_OUT-1:0]  wrOr,
  input  logic [TERM_W-1:0] rdTerm,
  output logic [ROW_W-1:0]  rdAnd,
  output logic [N_OUT-1:0]  rdOr,
  input  logic [N_IN-1:0]   inVec,
  output logic [N_OUT-1:0]  outVec
);
  pla_strb_t                         strb;
  logic [N_TERM-1:0][ROW_W-1:0]      andPlane;
  logic [N_TERM-1:0][N_OUT-1:0]      orPlane;

  pla_ctrl #(.N_TERM(N_TERM), .TERM_W(TERM_W)) ctrl_i (
    .clrReq(clrReq), .clrMode(clrMode), .wrEn(wrEn), .wrTerm(wrTerm), .strb(strb)
  );

  pla_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TERM_W(TERM_W)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrTerm(wrTerm), .wrAnd(wrAnd), .wrOr(wrOr),
    .rdTerm(rdTerm), .rdAnd(rdAnd), .rdOr(rdOr), .andPlane(andPlane), .orPlane(orPlane)
  );

  pla_eval #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) eval_i (
    .inVec(inVec), .andPlane(andPlane), .orPlane(orPlane), .outVec(outVec)
  );
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  localparam int TERM_W = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int ROW_W  = 2 * N_IN
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          clrReq,
  input logic                          clrMode,
  input logic                          wrEn,
  input logic [TERM_W-1:0]             wrTerm,
  input logic [ROW_W-1:0]              wrAnd,
  input logic [N_OUT-1:0]              wrOr,
  input logic [N_OUT-1:0]              outVec,
  input logic [N_TERM-1:0][ROW_W-1:0]  andPlane,
  input logic [N_TERM-1:0][N_OUT-1:0]  orPlane
);
  logic wrOk;
  assign wrOk = wrEn && !clrReq && (32'(wrTerm) < 32'(N_TERM));

  // R2
  row_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |=> (andPlane[$past(wrTerm)] == $past(wrAnd)) && (orPlane[$past(wrTerm)] == $past(wrOr)));

  // R6
  clear_fused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && clrMode) |=> (andPlane == '1) && (orPlane == '1));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !clrMode && wrEn) |=> (andPlane == '0) && (orPlane == '0));

  // R8
  range_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !clrReq && (32'(wrTerm) >= 32'(N_TERM))) |=> $stable(andPlane) && $stable(orPlane));

  // R5
  no_term_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (orPlane == '0) |-> (outVec == '0));

  // R1
  fused_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (andPlane == '1) |-> (outVec == '0));
endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) chk_i (
  .clk(clk), .rstN(rstN), .clrReq(clrReq), .clrMode(clrMode), .wrEn(wrEn),
  .wrTerm(wrTerm), .wrAnd(wrAnd), .wrOr(wrOr), .outVec(outVec),
  .andPlane(andPlane), .orPlane(orPlane)
);

// File: tb/pla_core_tb.sv
module pla_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int NT = 5;
  localparam int NO = 4;
  localparam int TW = 3;
  localparam int RW = 2 * NI;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrReq = 1'b0, clrMode = 1'b0, wrEn = 1'b0;
  logic [TW-1:0] wrTerm = '0, rdTerm = '0;
  logic [RW-1:0] wrAnd = '0;
  logic [NO-1:0] wrOr = '0;
  logic [NI-1:0] inVec = '0;
  logic [RW-1:0] rdAnd;
  logic [NO-1:0] rdOr;
  logic [NO-1:0] outVec;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit finished = 0;

  logic [RW-1:0] refAnd [NT];
  logic [NO-1:0] refOr  [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut_i (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .clrMode(clrMode), .wrEn(wrEn),
    .wrTerm(wrTerm), .wrAnd(wrAnd), .wrOr(wrOr), .rdTerm(rdTerm),
    .rdAnd(rdAnd), .rdOr(rdOr), .inVec(inVec), .outVec(outVec)
  );

  // behavioural reference model of the stored personality
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NT; t++) begin refAnd[t] = '1; refOr[t] = '1; end
    end else if (clrReq) begin
      for (int t = 0; t < NT; t++) begin
        refAnd[t] = clrMode ? '1 : '0;
        refOr[t]  = clrMode ? '1 : '0;
      end
    end else if (wrEn && int'(wrTerm) < NT) begin
      refAnd[wrTerm] = wrAnd;
      refOr[wrTerm]  = wrOr;
    end
  end

  function automatic logic [NO-1:0] refEval(input logic [NI-1:0] v);
    logic [NO-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      bit hit = 1;
      for (int i = 0; i < NI; i++) begin
        int lit = {refAnd[t][2*i+1], refAnd[t][2*i]};
        if (lit == 3) hit = 0;
        if (lit == 1 && !v[i]) hit = 0;
        if (lit == 2 && v[i]) hit = 0;
      end
      for (int j = 0; j < NO; j++) if (hit && refOr[t][j]) r[j] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NO-1:0] exampleOut(input logic [NI-1:0] v);
    logic a = v[0], b = v[1], c = v[2];
    return {(!b && c) || a, (a && b) || (!b && !c), (a && b) || (a && !c), (!b && !c) || a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({phase, " out"}, 32'(outVec), 32'(refEval(inVec)));
      check({phase, " readback"}, {16'(rdAnd), 16'(rdOr)},
            (int'(rdTerm) < NT) ? {16'(refAnd[rdTerm]), 16'(refOr[rdTerm])} : 32'h0);
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic writeRow(input int t, input logic [RW-1:0] a, input logic [NO-1:0] o);
    wrEn = 1; wrTerm = TW'(t); wrAnd = a; wrOr = o; rdTerm = TW'(t);
    cyc();
    wrEn = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: fused reset state
    for (int t = 0; t < NT; t++) begin
      rdTerm = TW'(t); inVec = NI'(t);
      cyc(); @(negedge clk);
      check("R1 reset and", 32'(rdAnd), 32'h3f);
      check("R1 reset or", 32'(rdOr), 32'hf);
      check("R1 reset out", 32'(outVec), 32'h0);
    end
    // R6 blank clear
    phase = "R6";
    clrReq = 1; clrMode = 0; cyc(); clrReq = 0;
    @(negedge clk);
    check("R6 blank and", 32'(rdAnd), 32'h0);
    check("R5 blank out", 32'(outVec), 32'h0);
    // R2 load shared-term example
    phase = "R2";
    writeRow(0, 6'b000101, 4'b0110);
    @(negedge clk);
    check("R2 row0 and", 32'(rdAnd), 32'h05);
    check("R2 row0 or", 32'(rdOr), 32'h6);
    writeRow(1, 6'b011000, 4'b1000);
    writeRow(2, 6'b100001, 4'b0010);
    writeRow(3, 6'b101000, 4'b0101);
    writeRow(4, 6'b000001, 4'b1001);
    // R10 / R4 exhaustive sweep, R9 same-cycle response
    phase = "R10";
    for (int v = 0; v < 8; v++) begin
      inVec = NI'(v); cyc(); @(negedge clk);
      check("R10 example", 32'(outVec), 32'(exampleOut(NI'(v))));
      inVec = NI'(7 - v); #1;
      check("R9 comb", 32'(outVec), 32'(exampleOut(NI'(7 - v))));
      check("R4 shared", 32'(outVec), 32'(refEval(NI'(7 - v))));
    end
    // R8 out-of-range write
    phase = "R8";
    inVec = 3'b001;
    wrEn = 1; wrTerm = 3'd7; wrAnd = '0; wrOr = '1; rdTerm = 3'd4; cyc(); wrEn = 0;
    @(negedge clk);
    check("R8 row4", {16'(rdAnd), 16'(rdOr)}, {16'h01, 16'h9});
    check("R8 out", 32'(outVec), 32'(exampleOut(3'b001)));
    // R3 forced-zero cell and polarity
    phase = "R3";
    writeRow(4, 6'b000011, 4'b1001);
    for (int v = 0; v < 8; v++) begin inVec = NI'(v); cyc(); end
    writeRow(4, 6'b000010, 4'b1000); // term = A'
    inVec = 3'b000; cyc(); @(negedge clk);
    check("R3 complement", 32'(outVec[3]), 32'h1);
    // R5 all-ignore term
    phase = "R5";
    clrReq = 1; clrMode = 0; cyc(); clrReq = 0;
    writeRow(2, 6'b000000, 4'b0100);
    for (int v = 0; v < 8; v++) begin
      inVec = NI'(v); cyc(); @(negedge clk);
      check("R5 all-ignore", 32'(outVec), 32'h4);
    end
    // R7 clear beats write
    phase = "R7";
    clrReq = 1; clrMode = 1; wrEn = 1; wrTerm = 3'd2; wrAnd = '0; wrOr = '1; rdTerm = 3'd2;
    cyc(); clrReq = 0; wrEn = 0;
    @(negedge clk);
    check("R7 row2", {16'(rdAnd), 16'(rdOr)}, {16'h3f, 16'hf});
    check("R7 out", 32'(outVec), 32'h0);
    clrReq = 1; clrMode = 0; wrEn = 1; cyc(); clrReq = 0; wrEn = 0;
    @(negedge clk);
    check("R7 blank row2", {16'(rdAnd), 16'(rdOr)}, 32'h0);
    cyc();
    summary();
  end
endmodule